// File: doc/BRIEF.md
# BCD Time-of-Day Clock with Alarm

This block keeps wall-clock time in 12-hour form, with separate BCD fields for tenths of a second, seconds, minutes and hours. Bit 7 of the hours field is the PM flag. A line-frequency strobe (`line_tick`, one clock wide per mains cycle) drives a prescaler. The prescaler turns 5 strobes (50 Hz mains) or 6 strobes (60 Hz mains) into one tenth-of-a-second step.

Software reaches the four fields through a small register port: `addr`, `wr_en`, `rd_en`, `wdata` and a combinational `rdata`. The order of accesses protects the time against carries in mid-access. A read of hours snapshots all four fields, and later reads see that snapshot until tenths is read. A write of hours stops the count until tenths is written. When `alarm_sel` is high, writes go to a second set of four alarm fields. `alarm_irq` pulses for one cycle when a tenth step lands on the alarm time.

The register port has no back-pressure: every access completes in the cycle it is presented. There is no valid/ready handshake because no data stream passes through the block. Field addresses are tenths = 0, seconds = 1, minutes = 2 and hours = 3.

Top module: `tod_clock`

## Requirements
- R1: After reset, the time fields read tenths 0x00, seconds 0x00, minutes 0x00 and hours 0x01 (1 AM). The clock is stopped, so ticks do not advance it. `alarm_irq` is low. Writing only tenths with 0x00 starts the count from 1:00:00.0.
- R2: With `sel_60hz` = 0, every 5th `line_tick` advances tenths by one. With `sel_60hz` = 1, every 6th does. The count restarts from zero after each tenths write.
- R3: The fields count in BCD. Tenths run 0 to 9 and carry into seconds. Seconds and minutes run 00 to 59, and each carries into the next field.
- R4: The hours value in bits 4:0 runs 01 to 12, and 12 is followed by 01. The PM flag in bit 7 toggles only on the step from 11:59:59.9 to 12:00:00.0.
- R5: A read of hours (address 3) returns the live value and freezes what later reads return. Later reads return the values from the moment of the hours read, while counting continues underneath. The next tenths read (address 0) returns the frozen tenths and ends the freeze.
- R6: Reads of tenths, seconds or minutes while the time is not frozen return live values and do not freeze.
- R7: A time write to hours stops the count, and further ticks have no effect. A time write to tenths restarts the count.
- R8: With `alarm_sel` = 1, writes load the alarm fields. The time fields and the running state are left unchanged.
- R9: `alarm_irq` is high for exactly one cycle, starting when a tenth step makes the time equal to the alarm fields. This holds for alarms whose seconds field is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_tick | input | 1 | One-cycle strobe per mains cycle |
| sel_60hz | input | 1 | 1: 6 strobes per tenth; 0: 5 strobes per tenth |
| alarm_sel | input | 1 | 1: writes target the alarm fields |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; applies the freeze and release effects |
| addr | input | 2 | Field select: 0 tenths, 1 seconds, 2 minutes, 3 hours |
| wdata | input | 8 | Write data (BCD) |
| rdata | output | 8 | Read data for `addr` (BCD) |
| alarm_irq | output | 1 | One-cycle alarm pulse |

## Verification
The bench builds the block with the default prescale limits, 5 and 6 strobes per tenth. With those values a single tenth step takes only a handful of cycles. Every carry can then be exercised by preloading the time one tenth before the boundary: the seconds, minutes and hours carries, the 09 to 10 and 12 to 01 hour steps, and both PM flips. The alarm test uses the same preload to reach a match with a zero seconds field in a few tens of cycles.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int unsigned FIELDS = 4;
  localparam logic [1:0] A_TN = 2'd0;
  localparam logic [1:0] A_HR = 2'd3;

  typedef logic [FIELDS-1:0][7:0] tod_t;

  function automatic logic [7:0] field_mask(input int unsigned idx);
    case (idx)
      0:       return 8'h0F;
      3:       return 8'h9F;
      default: return 8'h7F;
    endcase
  endfunction

  // {carry, next}
  function automatic logic [8:0] bcd_step(input logic [7:0] v, input logic [7:0] last);
    if (v == last)          return 9'h100;
    else if (v[3:0] == 4'h9) return {1'b0, v[7:4] + 4'd1, 4'h0};
    else                    return {1'b0, v + 8'd1};
  endfunction
endpackage

// File: rtl/tod_prescale.sv
module tod_prescale #(
  parameter int unsigned TICKS_50 = 5,
  parameter int unsigned TICKS_60 = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sel_60hz,
  input  logic clear,
  output logic step
);
  localparam int unsigned TMAX = (TICKS_60 > TICKS_50) ? TICKS_60 : TICKS_50;
  localparam int unsigned CW   = $clog2(TMAX + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last = sel_60hz ? CW'(TICKS_60 - 1) : CW'(TICKS_50 - 1);
  assign step = tick && !clear && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (!rst_n || clear)    cnt_q <= '0;
    else if (tick)          cnt_q <= (cnt_q == last) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/tod_advance.sv
module tod_advance
  import tod_pkg::*;
(
  input  tod_t cur,
  output tod_t nxt
);
  logic [FIELDS-1:0] cy;
  assign cy[0] = 1'b1;

  genvar i;
  generate
    for (i = 0; i < 3; i++) begin : g_low
      localparam logic [7:0] LAST = (i == 0) ? 8'h09 : 8'h59;
      logic [8:0] s;
      assign s         = bcd_step(cur[i], LAST);
      assign nxt[i]    = cy[i] ? s[7:0] : cur[i];
      assign cy[i+1]   = cy[i] & s[8];
    end
  endgenerate

  logic [4:0] h;
  assign h = cur[3][4:0];

  always_comb begin
    nxt[3] = cur[3];
    if (cy[3]) begin
      if (h == 5'h12)      nxt[3][4:0] = 5'h01;
      else if (h == 5'h09) nxt[3][4:0] = 5'h10;
      else                 nxt[3][4:0] = h + 5'd1;
      if (h == 5'h11)      nxt[3][7]   = ~cur[3][7];
    end
  end
endmodule

// File: rtl/tod_rdlatch.sv
module tod_rdlatch
  import tod_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  tod_t       live,
  output logic [7:0] rdata,
  output logic       frozen
);
  tod_t snap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frozen <= 1'b0;
      snap_q <= '0;
    end else if (rd_en) begin
      if (addr == A_HR && !frozen) begin
        snap_q <= live;
        frozen <= 1'b1;
      end else if (addr == A_TN) begin
        frozen <= 1'b0;
      end
    end
  end

  assign rdata = frozen ? snap_q[addr] : live[addr];
endmodule

// File: rtl/tod_clock.sv
module tod_clock
  import tod_pkg::*;
#(
  parameter int unsigned TICKS_50 = 5,
  parameter int unsigned TICKS_60 = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_tick,
  input  logic       sel_60hz,
  input  logic       alarm_sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       alarm_irq
);
  tod_t time_q, alarm_q, nxt;
  logic halted_q, step, frozen, wr_time, wr_alarm, pre_clear;

  assign wr_time   = wr_en && !alarm_sel;
  assign wr_alarm  = wr_en &&  alarm_sel;
  assign pre_clear = halted_q || (wr_time && (addr == A_TN || addr == A_HR));

  tod_prescale #(.TICKS_50(TICKS_50), .TICKS_60(TICKS_60)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(line_tick), .sel_60hz(sel_60hz),
    .clear(pre_clear), .step(step)
  );

  tod_advance u_adv (.cur(time_q), .nxt(nxt));

  tod_rdlatch u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr),
    .live(time_q), .rdata(rdata), .frozen(frozen)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_q    <= {8'h01, 8'h00, 8'h00, 8'h00};
      alarm_q   <= '0;
      halted_q  <= 1'b1;
      alarm_irq <= 1'b0;
    end else begin
      for (int i = 0; i < FIELDS; i++) begin
        if (wr_time && addr == 2'(i))       time_q[i]  <= wdata & field_mask(i);
        else if (step)                      time_q[i]  <= nxt[i];
        if (wr_alarm && addr == 2'(i))      alarm_q[i] <= wdata & field_mask(i);
      end
      if (wr_time && addr == A_HR)          halted_q <= 1'b1;
      else if (wr_time && addr == A_TN)     halted_q <= 1'b0;
      alarm_irq <= step && !wr_time && (nxt == alarm_q);
    end
  end
endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk
  import tod_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       line_tick,
  input logic       wr_en,
  input logic       rd_en,
  input logic [1:0] addr,
  input logic       alarm_irq,
  input logic       halted_q,
  input logic       step,
  input logic       frozen,
  input tod_t       time_q,
  input tod_t       alarm_q
);
  // R9
  a_r9_irq_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> (time_q == alarm_q));
  // R9
  a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |=> !alarm_irq);
  // R2
  a_r2_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> line_tick);
  // R7
  a_r7_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_q && !wr_en) |=> $stable(time_q));
  // R5
  a_r5_freeze_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !(rd_en && addr == A_TN)) |=> frozen);
endmodule

bind tod_clock tod_clock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .wr_en(wr_en),
  .rd_en(rd_en), .addr(addr), .alarm_irq(alarm_irq), .halted_q(halted_q),
  .step(step), .frozen(frozen), .time_q(time_q), .alarm_q(alarm_q)
);

// File: tb/tod_clock_test.sv
module tod_clock_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic line_tick = 1'b0, sel_60hz = 1'b0, alarm_sel = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic alarm_irq;

  int errors = 0, checks = 0, irq_count = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tod_clock uut (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .sel_60hz(sel_60hz),
    .alarm_sel(alarm_sel), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .alarm_irq(alarm_irq)
  );

  always @(posedge clk) if (alarm_irq) irq_count++;

  typedef struct packed {
    logic       sel;
    logic [7:0] s_hr, s_mn, s_sc, s_tn;
    logic [7:0] e_hr, e_mn, e_sc, e_tn;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h01, 8'h00, 8'h00, 8'h00,  8'h01, 8'h00, 8'h00, 8'h01},
    '{1'b1, 8'h01, 8'h00, 8'h00, 8'h09,  8'h01, 8'h00, 8'h01, 8'h00},
    '{1'b0, 8'h01, 8'h00, 8'h59, 8'h09,  8'h01, 8'h01, 8'h00, 8'h00},
    '{1'b1, 8'h01, 8'h59, 8'h59, 8'h09,  8'h02, 8'h00, 8'h00, 8'h00},
    '{1'b0, 8'h09, 8'h59, 8'h59, 8'h09,  8'h10, 8'h00, 8'h00, 8'h00},
    '{1'b1, 8'h11, 8'h59, 8'h59, 8'h09,  8'h92, 8'h00, 8'h00, 8'h00},
    '{1'b0, 8'h12, 8'h59, 8'h59, 8'h09,  8'h01, 8'h00, 8'h00, 8'h00},
    '{1'b1, 8'h91, 8'h59, 8'h59, 8'h09,  8'h12, 8'h00, 8'h00, 8'h00},
    '{1'b0, 8'h92, 8'h59, 8'h59, 8'h09,  8'h81, 8'h00, 8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); line_tick = 1'b1;
      @(negedge clk); line_tick = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n, c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R1 irq low", {7'd0, alarm_irq}, 8'h00);
    rd_chk("R1 reset hours",  2'd3, 8'h01);
    rd_chk("R1 reset min",    2'd2, 8'h00);
    rd_chk("R1 reset sec",    2'd1, 8'h00);
    rd_chk("R1 reset tenths", 2'd0, 8'h00);
    ticks(6);
    rd_chk("R1 stopped after reset", 2'd0, 8'h00);
    wr(2'd0, 8'h00);
    ticks(5);
    rd_chk("R1 nudge tenths", 2'd0, 8'h01);
    rd_chk("R1 nudge hours",  2'd3, 8'h01);
    rd_chk("R1 nudge release", 2'd0, 8'h01);

    for (int i = 0; i < NV; i++) begin
      sel_60hz = VECS[i].sel;
      n = VECS[i].sel ? 6 : 5;
      wr(2'd3, VECS[i].s_hr);
      wr(2'd2, VECS[i].s_mn);
      wr(2'd1, VECS[i].s_sc);
      wr(2'd0, VECS[i].s_tn);
      ticks(n - 1);
      rd_chk("R2 no step before limit", 2'd0, VECS[i].s_tn);
      ticks(1);
      rd_chk("R4 hours",   2'd3, VECS[i].e_hr);
      rd_chk("R3 minutes", 2'd2, VECS[i].e_mn);
      rd_chk("R3 seconds", 2'd1, VECS[i].e_sc);
      rd_chk("R3 tenths",  2'd0, VECS[i].e_tn);
    end

    // running at 12:00:00.0 AM... actually 1:00:00.0 PM (0x81), 50 Hz
    rd_chk("R5 hours live", 2'd3, 8'h81);
    ticks(5);
    rd_chk("R5 frozen sec",    2'd1, 8'h00);
    rd_chk("R5 frozen tenths", 2'd0, 8'h00);
    rd_chk("R5 released tenths", 2'd0, 8'h01);

    rd_chk("R6 minutes", 2'd2, 8'h00);
    ticks(5);
    rd_chk("R6 tenths live", 2'd0, 8'h02);

    wr(2'd3, 8'h81);
    ticks(10);
    rd_chk("R7 halted tenths", 2'd0, 8'h02);
    wr(2'd0, 8'h05);
    ticks(4);
    rd_chk("R7 restart no early step", 2'd0, 8'h05);
    ticks(1);
    rd_chk("R7 restart step", 2'd0, 8'h06);

    alarm_sel = 1'b1;
    wr(2'd3, 8'h01);
    wr(2'd2, 8'h01);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h00);
    alarm_sel = 1'b0;
    ticks(5);
    rd_chk("R8 time still runs", 2'd0, 8'h07);
    rd_chk("R8 hours untouched", 2'd3, 8'h81);
    rd_chk("R8 release", 2'd0, 8'h07);

    wr(2'd3, 8'h01);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h59);
    wr(2'd0, 8'h08);
    c0 = irq_count;
    ticks(5);
    check("R9 no irq before match", 8'(irq_count - c0), 8'h00);
    ticks(5);
    check("R9 irq on zero-seconds match", 8'(irq_count - c0), 8'h01);
    rd_chk("R9 time at match sec", 2'd1, 8'h00);
    ticks(5);
    check("R9 single pulse", 8'(irq_count - c0), 8'h01);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule